// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

This block is a single-cycle 32-bit arithmetic unit for signal-processing code. It takes two operands and a 3-bit operation code and gives a 32-bit result in the same cycle. The result path has no register. The operations are:

- a signed add that wraps but records overflow;
- a signed add and a signed subtract that clamp to the most positive or most negative value on overflow;
- a word-by-halfword signed multiply that keeps product bits 47..16;
- a leading-zero count;
- a sign extension of the low halfword.

A single registered sticky flag records overflow from any of the three add/subtract operations. Once set, the flag stays set until a synchronous clear input is raised. Software can read the flag to find out whether a block of computations lost precision. It then clears the flag before the next block.

Top module: `sat_dsp_unit`

## Requirements
- R1: `op_i` encodes 0 = flagging add, 1 = saturating add, 2 = saturating subtract, 3 = word×halfword multiply, 4 = leading-zero count, 5 = halfword sign extend. Codes 6 and 7 give a zero result and never set the flag.
- R2: The flagging add (code 0) outputs the 32-bit wrapped sum `a_i + b_i`, even when it overflows.
- R3: An add (code 0 or 1) overflows when `a_i[31]` equals `b_i[31]` and bit 31 of the sum differs from `a_i[31]`. Such an overflow sets the sticky flag at the next clock edge.
- R4: On overflow, the saturating add outputs 32'h8000_0000 if `a_i[31]` is 1 and 32'h7FFF_FFFF otherwise. Without overflow it outputs the wrapped sum.
- R5: The saturating subtract overflows when `a_i[31]` differs from `b_i[31]` and bit 31 of `a_i - b_i` differs from `a_i[31]`. On overflow it sets the flag and clamps as in R4. Otherwise it outputs the difference.
- R6: The multiply (code 3) forms the signed product of `a_i` and the signed value of `b_i[15:0]`. It outputs bits 47..16 of that product. `b_i[31:16]` is ignored.
- R7: The leading-zero count outputs the number of zero bits above the highest set bit of `a_i`. The count is 32 for zero and 0 when bit 31 is set.
- R8: The sign extend outputs `a_i[15:0]` with bit 15 copied into bits 31..16.
- R9: Once set, the flag stays set while `q_clr_i` is low, whatever the operation and operands.
- R10: Reset (`rst_n` low at a clock edge) and `q_clr_i` high at a clock edge both make the flag 0. The clear wins over an overflow in the same cycle.
- R11: `result_o` depends only on the present `op_i`, `a_i` and `b_i`, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| q_clr_i | input | 1 | Synchronous clear of the sticky flag |
| result_o | output | 32 | Combinational result |
| q_flag_o | output | 1 | Sticky overflow flag |

## Verification
The flag is the only state in the block, so a wrong internal state shows up as a wrong `q_flag_o` one clock edge after the vector that should have changed it. The flag stays wrong until the next clear, so one missed or spurious set is never hidden by later traffic.

Errors in the result path have no delay. A wrong clamp, a wrong product slice or an off-by-one leading-zero count appears on `result_o` in the cycle its operands are applied. For that reason the bench sweeps boundary operand pairs (sign edges, halfword edges, zero and all-ones) through every code, and compares result and flag after each vector.

// File: rtl/sat_dsp_pkg.sv
// Shared operation codes for the saturating DSP arithmetic unit.
// Assumes a 3-bit operation field; unlisted codes are reserved.
package sat_dsp_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_FLAG = 3'd0,
        OP_ADD_SAT  = 3'd1,
        OP_SUB_SAT  = 3'd2,
        OP_MUL_WH   = 3'd3,
        OP_LZCNT    = 3'd4,
        OP_SEXT_H   = 3'd5,
        OP_RSVD6    = 3'd6,
        OP_RSVD7    = 3'd7
    } dsp_op_e;
endpackage

// File: rtl/sat_addsub.sv
// Signed two's-complement add or subtract with overflow detection.
// It outputs both the wrapped and the clamped result.
// IS_SUB picks the variant at elaboration time. Assumes DW >= 2.
module sat_addsub #(
    parameter int DW     = 32,
    parameter bit IS_SUB = 1'b0
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] wrap_o,
    output logic [DW-1:0] sat_o,
    output logic          ovf_o
);
    localparam int MSB = DW - 1;
    localparam logic [DW-1:0] MAX_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MAX_NEG = {1'b1, {(DW-1){1'b0}}};

    logic sign_rule;

    generate
        if (IS_SUB) begin : g_sub
            // Difference; overflow needs operands of opposite sign.
            assign wrap_o    = a - b;
            assign sign_rule = a[MSB] ^ b[MSB];
        end else begin : g_add
            // Sum; overflow needs operands of equal sign.
            assign wrap_o    = a + b;
            assign sign_rule = ~(a[MSB] ^ b[MSB]);
        end
    endgenerate

    // Overflow: the result sign moved away from the first operand's sign.
    assign ovf_o = sign_rule & (wrap_o[MSB] ^ a[MSB]);

    // Clamp toward the first operand's sign on overflow.
    always_comb begin
        if (ovf_o) sat_o = a[MSB] ? MAX_NEG : MAX_POS;
        else       sat_o = wrap_o;
    end
endmodule

// File: rtl/mul_word_half.sv
// Signed word-by-halfword multiply that keeps the product bits above
// the low HW bits. Assumes the caller passes only the low halfword.
module mul_word_half #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [HW-1:0] b_lo,
    output logic [DW-1:0] res_o
);
    localparam int PW = DW + HW;

    logic signed [PW-1:0] a_x;
    logic signed [PW-1:0] b_x;
    logic signed [PW-1:0] prod;
    logic                 unused_low;

    // Sign-extend both factors to the full product width.
    assign a_x  = {{HW{a[DW-1]}}, a};
    assign b_x  = {{DW{b_lo[HW-1]}}, b_lo};
    assign prod = a_x * b_x;

    // Drop the low HW bits; the top DW bits are the result.
    assign res_o      = prod[PW-1:HW];
    assign unused_low = ^prod[HW-1:0];
endmodule

// File: rtl/lead_zero_cnt.sv
// Leading-zero counter: the number of zeros above the highest set bit.
// An all-zero input gives DW.
module lead_zero_cnt #(
    parameter int DW = 32,
    parameter int CW = $clog2(DW + 1)
) (
    input  logic [DW-1:0] a,
    output logic [CW-1:0] cnt_o
);
    // Scan upward; the highest set bit writes the count last.
    always_comb begin
        cnt_o = CW'(DW);
        for (int i = 0; i < DW; i++) begin
            if (a[i]) cnt_o = CW'(DW - 1 - i);
        end
    end
endmodule

// File: rtl/sext_half.sv
// Sign extension of a HW-bit value to DW bits.
module sext_half #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic [HW-1:0] a_lo,
    output logic [DW-1:0] res_o
);
    // Copy the halfword sign bit into the upper bits.
    assign res_o = {{(DW-HW){a_lo[HW-1]}}, a_lo};
endmodule

// File: rtl/q_flag_reg.sv
// Sticky overflow flag register. Synchronous active-low reset.
// A clear wins over a set in the same cycle.
module q_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic set,
    output logic q
);
    // Hold the flag; reset and clear force it low, set forces it high.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (set) q <= 1'b1;
    end
endmodule

// File: rtl/sat_dsp_unit.sv
// Saturating DSP arithmetic unit (top).
// The result is combinational from op_i, a_i and b_i.
// Any add/subtract overflow sets a registered sticky flag, which only
// q_clr_i or reset lowers. Assumes HW < DW.
module sat_dsp_unit
    import sat_dsp_pkg::*;
#(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic            q_clr_i,
    output logic [DW-1:0]   result_o,
    output logic            q_flag_o
);
    localparam int CW = $clog2(DW + 1);

    dsp_op_e       op;
    logic [DW-1:0] add_wrap, add_sat, sub_wrap, sub_sat;
    logic          add_ovf, sub_ovf;
    logic [DW-1:0] mul_res, sext_res;
    logic [CW-1:0] lz_cnt;
    logic          q_set;

    assign op = dsp_op_e'(op_i);

    sat_addsub #(.DW(DW), .IS_SUB(1'b0)) i_add (
        .a(a_i), .b(b_i), .wrap_o(add_wrap), .sat_o(add_sat), .ovf_o(add_ovf)
    );

    sat_addsub #(.DW(DW), .IS_SUB(1'b1)) i_sub (
        .a(a_i), .b(b_i), .wrap_o(sub_wrap), .sat_o(sub_sat), .ovf_o(sub_ovf)
    );

    mul_word_half #(.DW(DW), .HW(HW)) i_mul (
        .a(a_i), .b_lo(b_i[HW-1:0]), .res_o(mul_res)
    );

    lead_zero_cnt #(.DW(DW), .CW(CW)) i_lzc (
        .a(a_i), .cnt_o(lz_cnt)
    );

    sext_half #(.DW(DW), .HW(HW)) i_sext (
        .a_lo(a_i[HW-1:0]), .res_o(sext_res)
    );

    // Pick the result for the current code; reserved codes give zero.
    always_comb begin
        case (op)
            OP_ADD_FLAG: result_o = add_wrap;
            OP_ADD_SAT:  result_o = add_sat;
            OP_SUB_SAT:  result_o = sub_sat;
            OP_MUL_WH:   result_o = mul_res;
            OP_LZCNT:    result_o = {{(DW-CW){1'b0}}, lz_cnt};
            OP_SEXT_H:   result_o = sext_res;
            default:     result_o = '0;
        endcase
    end

    // Flag set request: overflow from any add or subtract operation.
    always_comb begin
        case (op)
            OP_ADD_FLAG, OP_ADD_SAT: q_set = add_ovf;
            OP_SUB_SAT:              q_set = sub_ovf;
            default:                 q_set = 1'b0;
        endcase
    end

    q_flag_reg i_qreg (
        .clk(clk), .rst_n(rst_n), .clr(q_clr_i), .set(q_set), .q(q_flag_o)
    );
endmodule

// File: rtl/sat_dsp_unit_chk.sv
// Assertion checker for sat_dsp_unit, attached by bind. Port-level only.
module sat_dsp_unit_chk #(
    parameter int DW = 32,
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_i,
    input logic [DW-1:0] a_i,
    input logic [DW-1:0] b_i,
    input logic          q_clr_i,
    input logic [DW-1:0] result_o,
    input logic          q_flag_o
);
    localparam int MSB = DW - 1;

    logic [DW-1:0] chk_sum, chk_diff;
    logic          chk_add_ovf, chk_sub_ovf;

    // Independent overflow view from the operand and result signs.
    assign chk_sum     = a_i + b_i;
    assign chk_diff    = a_i - b_i;
    assign chk_add_ovf = (a_i[MSB] == b_i[MSB]) && (chk_sum[MSB] != a_i[MSB]);
    assign chk_sub_ovf = (a_i[MSB] != b_i[MSB]) && (chk_diff[MSB] != a_i[MSB]);

    assert_q_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag_o && !q_clr_i) |=> q_flag_o);

    assert_q_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q_clr_i |=> !q_flag_o);

    assert_q_set_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_i == 3'd0 || op_i == 3'd1) && chk_add_ovf && !q_clr_i) |=> q_flag_o);

    assert_q_set_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && chk_sub_ovf && !q_clr_i) |=> q_flag_o);

    assert_qadd_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd1 && a_i[MSB] == b_i[MSB]) |-> result_o[MSB] == a_i[MSB]);

    assert_lzcnt_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd4 && a_i[MSB]) |-> result_o == '0);

    assert_sext_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd5) |-> result_o[MSB:HW] == {(DW-HW){a_i[HW-1]}});

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2:1] == 2'b11) |-> result_o == '0);

    assert_rsvd_noset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2:1] == 2'b11 && !q_flag_o) |=> !q_flag_o);
endmodule

bind sat_dsp_unit sat_dsp_unit_chk #(.DW(DW), .HW(HW)) i_chk (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .q_clr_i(q_clr_i), .result_o(result_o), .q_flag_o(q_flag_o)
);

// File: tb/test_sat_dsp_unit.sv
// Near-exhaustive bench: boundary operand pairs through every code,
// then a pseudo-random phase, with a bench-side model of the flag.
module test_sat_dsp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] a_i = '0, b_i = '0;
    logic        q_clr_i = 1'b0;
    logic [31:0] result_o;
    logic        q_flag_o;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    bit  q_model = 1'b0;

    always #5 clk = ~clk;

    sat_dsp_unit i_sat_dsp_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .q_clr_i(q_clr_i), .result_o(result_o), .q_flag_o(q_flag_o)
    );

    function automatic logic [31:0] corner(input int k);
        case (k)
            0:  return 32'h0000_0000;
            1:  return 32'h0000_0001;
            2:  return 32'hFFFF_FFFF;
            3:  return 32'h7FFF_FFFF;
            4:  return 32'h8000_0000;
            5:  return 32'h0000_7FFF;
            6:  return 32'h0000_8000;
            7:  return 32'h0000_FFFF;
            8:  return 32'h0001_0000;
            9:  return 32'h4000_0000;
            10: return 32'hC000_0000;
            11: return 32'h1234_5678;
            12: return 32'h8000_0001;
            13: return 32'h7FFF_8000;
            14: return 32'hFFFF_8000;
            default: return 32'h00F0_0F00;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2/R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R1";
        endcase
    endfunction

    function automatic logic exp_ovf(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] s, d;
        s = a + b;
        d = a - b;
        if (op == 3'd0 || op == 3'd1) return (a[31] == b[31]) && (s[31] != a[31]);
        if (op == 3'd2) return (a[31] != b[31]) && (d[31] != a[31]);
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_res(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb;
        logic [63:0] p;
        int n;
        case (op)
            3'd0: return a + b;
            3'd1: return exp_ovf(op, a, b) ? (a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF) : a + b;
            3'd2: return exp_ovf(op, a, b) ? (a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF) : a - b;
            3'd3: begin
                sa = longint'($signed(a));
                sb = longint'($signed(b[15:0]));
                p = 64'(sa * sb);
                return p[47:16];
            end
            3'd4: begin
                n = 0;
                while (n < 32 && a[31-n] == 1'b0) n++;
                return 32'(n);
            end
            3'd5: return {{16{a[15]}}, a[15:0]};
            default: return 32'h0;
        endcase
    endfunction

    // Apply one vector; check the result this cycle and the flag after the edge.
    task automatic apply(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b, input logic clr);
        logic [31:0] er;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; q_clr_i = clr;
        #1;
        er = exp_res(op, a, b);
        checks++;
        if (result_o !== er) begin
            errors++;
            $display("FAIL %s R11 op=%0d a=%h b=%h actual=%h expected=%h",
                     req_of(op), op, a, b, result_o, er);
        end
        if (clr)                       q_model = 1'b0;
        else if (exp_ovf(op, a, b))    q_model = 1'b1;
        @(posedge clk);
        #1;
        checks++;
        if (q_flag_o !== q_model) begin
            errors++;
            $display("FAIL flag R3/R5/R9/R10 op=%0d a=%h b=%h clr=%0b actual=%0b expected=%0b",
                     op, a, b, clr, q_flag_o, q_model);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] x, y;
        // R10: reset holds the flag low, even with an overflowing add applied.
        op_i = 3'd1; a_i = 32'h7FFF_FFFF; b_i = 32'h1;
        repeat (3) begin
            @(posedge clk); #1;
            checks++;
            if (q_flag_o !== 1'b0) begin
                errors++;
                $display("FAIL R10 reset flag actual=%0b expected=0", q_flag_o);
            end
        end
        @(negedge clk); op_i = 3'd4; rst_n = 1'b1;

        // R10: clear beats an overflow in the same cycle; R9 sticky checks.
        apply(3'd0, 32'h7FFF_FFFF, 32'h1, 1'b1);
        apply(3'd2, 32'h8000_0000, 32'h1, 1'b0);
        apply(3'd3, 32'h0, 32'h0, 1'b0);
        apply(3'd1, 32'h1, 32'h1, 1'b0);
        apply(3'd2, 32'h8000_0000, 32'h1, 1'b1);
        // R1: reserved codes with overflow-like operands do not set the flag.
        apply(3'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        apply(3'd7, 32'h8000_0000, 32'h8000_0000, 1'b0);
        // R6: upper half of b ignored.
        apply(3'd3, 32'h1234_5678, 32'hFFFF_0002, 1'b0);
        apply(3'd3, 32'h1234_5678, 32'h0000_0002, 1'b0);

        // Corner sweep: every code on every boundary pair.
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                for (int op = 0; op < 8; op++) begin
                    apply(3'(op), corner(i), corner(j), ((i * 16 + j + op) % 11) == 5);
                end
            end
        end

        // Pseudo-random phase with xorshift operands.
        x = 32'h2468_ACE1; y = 32'h1357_9BDF;
        for (int k = 0; k < 3000; k++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            y ^= y << 13; y ^= y >> 17; y ^= y << 5;
            apply(3'(k % 8), x >> (k % 5), y, (k % 37) == 0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule